// File: doc/BRIEF.md
# Memory Area Controller with Boot Swap

This block sits between a processor bus and up to four external or on-chip memory devices. It splits the address space into four contiguous regions of 1 MByte each and gives every region its own chip select. Each region has its own settings: device data width (8, 16 or 32 bits), a wait-state count and a stop-state count. A processor access that is wider than the device in its region is broken into several back-to-back device cycles. The block moves bytes between the processor's lane-aligned data word and the device's low lanes, so software sees a 32-bit little-endian view of every region.

A swap input exchanges the decode of region 0, which is the one reached from address zero after reset, with region 3. A system can therefore boot from a ROM in region 0 and then map fast RAM in region 3 onto the reset address. The swap value is taken only while no access is in progress, so a transfer that has already started is never redirected.

The processor side uses a simple handshake. The processor presents a request when `ready` is high. The block later pulses `done`, with `err` and read data valid in that same cycle.

Top module: `memarea_ctrl`

## Requirements
- R1: With swap off, an accepted request whose address bits [23:20] equal k (k < 4) asserts only `cs[k]` for the whole access, and `cs` is never more than one-hot.
- R2: A request is rejected if its address bits [23:20] are 4 or more, if it is misaligned (a halfword with bit 0 set, or a word with bits [1:0] nonzero), or if its size code is 3. A rejected request yields `done` and `err` high in the cycle after acceptance, and no chip select is asserted. Size codes are 0 byte, 1 halfword, 2 word.
- R3: Each device cycle lasts W+1 clock cycles, where W is the region's wait count. For an access of B device cycles, `cs` stays high for B(W+1) cycles, `done` arrives B(W+1)+1 cycles after the request is driven, and `ready` is low while `cs` is high.
- R4: The number of device cycles B is set by the region's width code (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit). A word access takes 4 device cycles on an 8-bit region and 2 on a 16-bit region. A halfword access takes 2 device cycles on an 8-bit region. Every other access takes 1. `dev_addr` is the offset inside the region and grows by the device width in bytes at each new device cycle.
- R5: Read data is returned on the processor lanes that match the address. Byte i of the access, counted from the lowest address, lands in lane (addr[1:0]+i). All other lanes read zero. Bytes from a narrow device are assembled little-endian.
- R6: Writes place processor lane (offset[1:0]+i) on the device lanes, with device byte enables set only for the bytes being accessed. After the write, the device holds exactly the written bytes and no neighbouring byte is changed.
- R7: After `done`, a region with stop count S keeps `ready` low and `cs` low for S further cycles. `done` is never high while any `cs` is high.
- R8: With swap on, region-0 addresses select `cs[3]` and use region 3's width, wait and stop settings, region-3 addresses select `cs[0]`, and regions 1 and 2 are unchanged.
- R9: The swap setting resets to off. It is sampled only while the controller is idle, so changing `swap_in` during an access does not alter that access's chip select. A request applies the swap value of the previous idle cycle.
- R10: After reset `cs` is zero, `ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is high |
| addr | input | 24 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Lane-aligned write data |
| swap_in | input | 1 | Requested exchange of regions 0 and 3 |
| cfg_width | input | 8 | Width code per region, 2 bits each, region k at [2k+1:2k] |
| cfg_wait | input | 16 | Wait count per region, 4 bits each |
| cfg_stop | input | 16 | Stop count per region, 4 bits each |
| ready | output | 1 | Controller idle, request may be presented |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a rejection |
| rdata | output | 32 | Assembled read data, valid with `done` |
| cs | output | 4 | One chip select per region |
| dev_addr | output | 20 | Offset inside the selected region |
| dev_we | output | 1 | Device write strobe |
| dev_be | output | 4 | Device byte-lane enables |
| dev_wdata | output | 32 | Steered device write data |
| dev_rdata | input | 32 | Device read data |

## Verification
Every result has a fixed due cycle measured from the falling edge where the request is driven. A rejection completes at the next falling edge. A good access completes B(W+1)+1 falling edges later, and `ready` returns S edges after that. The bench counts falling edges from the request and samples `cs`, `dev_addr`, `done`, `rdata` and `ready` only at those edges, so latency, chip-select length, address stepping and the stop gap are each compared against values computed from B, W and S. The sweep covers every region, width code, size, legal offset, and several wait and stop values. A behavioural device model in the bench holds the memory contents, so write steering and read assembly are both checked against byte arithmetic.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_STOP = 2'd2
    } mac_st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [1:0] WC_8  = 2'd0;
    localparam logic [1:0] WC_16 = 2'd1;
    localparam logic [1:0] WC_32 = 2'd2;

    // Number of device cycles one processor access needs.
    function automatic logic [2:0] beats_of(input logic [1:0] sz, input logic [1:0] wc);
        logic [2:0] n;
        n = 3'd1;
        if (wc == WC_8) begin
            if (sz == SZ_WORD)      n = 3'd4;
            else if (sz == SZ_HALF) n = 3'd2;
        end else if (wc == WC_16) begin
            if (sz == SZ_WORD)      n = 3'd2;
        end
        return n;
    endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode #(
    parameter int ADDR_W  = 24,
    parameter int AREA_AW = 20,
    parameter int N_AREA  = 4,
    localparam int SEL_W  = $clog2(N_AREA),
    localparam int HI_W   = ADDR_W - AREA_AW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              swap,
    output logic [SEL_W-1:0]  sel,
    output logic              bad
);
    localparam logic [HI_W-1:0]  N_HI = HI_W'(N_AREA);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(N_AREA - 1);

    logic [HI_W-1:0]  hi;
    logic [SEL_W-1:0] raw;
    logic             misal;

    always_comb begin
        hi    = addr[ADDR_W-1:AREA_AW];
        raw   = hi[SEL_W-1:0];
        misal = (size == 2'd3)
              | ((size == 2'd1) & addr[0])
              | ((size == 2'd2) & (addr[1:0] != 2'b00));
        bad   = (hi >= N_HI) | misal;
        if (swap && raw == '0)        sel = LAST;
        else if (swap && raw == LAST) sel = '0;
        else                          sel = raw;
    end
endmodule

// File: rtl/mac_lanes.sv
module mac_lanes
    import mac_pkg::*;
(
    input  logic [1:0]       wcode,
    input  logic [1:0]       size,
    input  logic [1:0]       cur,
    input  logic [31:0]      wdata,
    output logic [3:0]       be,
    output logic [3:0][1:0]  tgt,
    output logic [31:0]      dwdata
);
    always_comb begin
        be = 4'b0001;
        if (wcode == WC_8) begin
            be = 4'b0001;
        end else if (wcode == WC_16) begin
            be = (size == SZ_BYTE) ? (4'b0001 << cur[0]) : 4'b0011;
        end else begin
            case (size)
                SZ_BYTE: be = 4'b0001 << cur;
                SZ_HALF: be = 4'b0011 << cur;
                default: be = 4'b1111;
            endcase
        end
    end

    for (genvar j = 0; j < 4; j++) begin : g_lane
        always_comb begin
            if (wcode == WC_8)       tgt[j] = cur;
            else if (wcode == WC_16) tgt[j] = {cur[1], j[0]};
            else                     tgt[j] = 2'(j);
            dwdata[8*j +: 8] = be[j] ? wdata[8*tgt[j] +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/memarea_ctrl.sv
module memarea_ctrl
    import mac_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int AREA_AW = 20,
    parameter int N_AREA  = 4,
    parameter int WS_W    = 4,
    localparam int SEL_W  = $clog2(N_AREA)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr,
    input  logic [1:0]               size,
    input  logic [31:0]              wdata,
    input  logic                     swap_in,
    input  logic [2*N_AREA-1:0]      cfg_width,
    input  logic [WS_W*N_AREA-1:0]   cfg_wait,
    input  logic [WS_W*N_AREA-1:0]   cfg_stop,
    output logic                     ready,
    output logic                     done,
    output logic                     err,
    output logic [31:0]              rdata,
    output logic [N_AREA-1:0]        cs,
    output logic [AREA_AW-1:0]       dev_addr,
    output logic                     dev_we,
    output logic [3:0]               dev_be,
    output logic [31:0]              dev_wdata,
    input  logic [31:0]              dev_rdata
);
    typedef struct packed {
        mac_st_e            st;
        logic               swap;
        logic [SEL_W-1:0]   sel;
        logic [1:0]         wcode;
        logic [1:0]         size;
        logic               we;
        logic [AREA_AW-1:0] cur;
        logic [2:0]         left;
        logic [WS_W-1:0]    wcnt;
        logic [WS_W-1:0]    scnt;
        logic [31:0]        wdata;
        logic [31:0]        rdata;
        logic               done;
        logic               err;
    } mac_state_t;

    mac_state_t q, d;

    logic [SEL_W-1:0] dec_sel;
    logic             dec_bad;
    logic [1:0]       new_wc;
    logic [3:0]       be;
    logic [3:0][1:0]  tgt;
    logic [31:0]      steer_wd;

    mac_decode #(.ADDR_W(ADDR_W), .AREA_AW(AREA_AW), .N_AREA(N_AREA)) u_dec (
        .addr (addr),
        .size (size),
        .swap (q.swap),
        .sel  (dec_sel),
        .bad  (dec_bad)
    );

    mac_lanes u_lanes (
        .wcode  (q.wcode),
        .size   (q.size),
        .cur    (q.cur[1:0]),
        .wdata  (q.wdata),
        .be     (be),
        .tgt    (tgt),
        .dwdata (steer_wd)
    );

    always_comb begin
        new_wc = cfg_width[dec_sel*2 +: 2];
        if (new_wc == 2'd3) new_wc = WC_32;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.swap = swap_in;
                if (req) begin
                    d.rdata = '0;
                    if (dec_bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st    = ST_ACC;
                        d.sel   = dec_sel;
                        d.wcode = new_wc;
                        d.size  = size;
                        d.we    = wr;
                        d.cur   = addr[AREA_AW-1:0];
                        d.left  = beats_of(size, new_wc) - 3'd1;
                        d.wcnt  = cfg_wait[dec_sel*WS_W +: WS_W];
                        d.wdata = wdata;
                    end
                end
            end
            ST_ACC: begin
                if (q.wcnt != '0) begin
                    d.wcnt = q.wcnt - 1'b1;
                end else begin
                    if (!q.we) begin
                        for (int j = 0; j < 4; j++) begin
                            if (be[j]) d.rdata[8*tgt[j] +: 8] = dev_rdata[8*j +: 8];
                        end
                    end
                    if (q.left == 3'd0) begin
                        d.done = 1'b1;
                        d.scnt = cfg_stop[q.sel*WS_W +: WS_W];
                        d.st   = (d.scnt == '0) ? ST_IDLE : ST_STOP;
                    end else begin
                        d.left = q.left - 3'd1;
                        d.cur  = q.cur + (AREA_AW'(1) << q.wcode);
                        d.wcnt = cfg_wait[q.sel*WS_W +: WS_W];
                    end
                end
            end
            ST_STOP: begin
                if (q.scnt <= WS_W'(1)) d.st = ST_IDLE;
                else                    d.scnt = q.scnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    for (genvar k = 0; k < N_AREA; k++) begin : g_cs
        assign cs[k] = (q.st == ST_ACC) && (q.sel == SEL_W'(k));
    end

    assign ready     = (q.st == ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign rdata     = q.rdata;
    assign dev_addr  = q.cur;
    assign dev_we    = (q.st == ST_ACC) && q.we;
    assign dev_be    = (q.st == ST_ACC) ? be : 4'b0000;
    assign dev_wdata = steer_wd;
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
    parameter int N_AREA = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_AREA-1:0] cs,
    input logic              ready,
    input logic              done,
    input logic              err
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs)); // R1

    AST_REJECT_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($past(cs) == '0)); // R2

    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs) |-> !ready); // R3

    AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs == '0)); // R7

    AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cs) && $past(|cs)) |-> $stable(cs)); // R9
endmodule

bind memarea_ctrl mac_chk #(.N_AREA(N_AREA)) u_mac_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .ready (ready),
    .done  (done),
    .err   (err)
);

// File: tb/tb_memarea_ctrl.sv
module tb_memarea_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        wr = 1'b0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        swap_in = 1'b0;
    logic [1:0]  cw [4];
    logic [3:0]  wt [4];
    logic [3:0]  sp [4];
    logic [7:0]  cfg_width;
    logic [15:0] cfg_wait, cfg_stop;
    logic        ready, done, err;
    logic [31:0] rdata;
    logic [3:0]  cs;
    logic [19:0] dev_addr;
    logic        dev_we;
    logic [3:0]  dev_be;
    logic [31:0] dev_wdata;
    logic [31:0] dev_rdata;
    logic [5:0]  ra;
    logic [7:0]  mem [4][64];

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign cfg_width = {cw[3], cw[2], cw[1], cw[0]};
    assign cfg_wait  = {wt[3], wt[2], wt[1], wt[0]};
    assign cfg_stop  = {sp[3], sp[2], sp[1], sp[0]};
    assign ra = dev_addr[5:0];

    memarea_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr), .size(size),
        .wdata(wdata), .swap_in(swap_in), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .cfg_stop(cfg_stop), .ready(ready), .done(done), .err(err), .rdata(rdata),
        .cs(cs), .dev_addr(dev_addr), .dev_we(dev_we), .dev_be(dev_be),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // behavioural devices
    always_comb begin
        dev_rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (cs[k]) begin
                case (cw[k])
                    2'd0: dev_rdata = {24'h0, mem[k][ra]};
                    2'd1: dev_rdata = {16'h0, mem[k][{ra[5:1], 1'b1}], mem[k][{ra[5:1], 1'b0}]};
                    default: dev_rdata = {mem[k][{ra[5:2], 2'd3}], mem[k][{ra[5:2], 2'd2}],
                                          mem[k][{ra[5:2], 2'd1}], mem[k][{ra[5:2], 2'd0}]};
                endcase
            end
        end
    end

    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (cs[k] && dev_we) begin
                for (int j = 0; j < 4; j++) begin
                    if (dev_be[j]) begin
                        case (cw[k])
                            2'd0: if (j == 0) mem[k][ra] <= dev_wdata[7:0];
                            2'd1: if (j < 2) mem[k][{ra[5:1], 1'b0} + j] <= dev_wdata[8*j +: 8];
                            default: mem[k][{ra[5:2], 2'b00} + j] <= dev_wdata[8*j +: 8];
                        endcase
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // results of the last access
    int          r_lat, r_cyc, r_chg, r_gap;
    logic [3:0]  r_cs;
    logic [19:0] r_last;
    logic [31:0] r_rd;
    logic        r_err, r_gapcs;

    task automatic do_acc(input logic [23:0] a, input logic w, input logic [1:0] sz,
                          input logic [31:0] wd);
        int n;
        logic [19:0] prev;
        n = 0;
        while (!ready && n < 100) begin @(negedge clk); n++; end
        req = 1'b1; addr = a; wr = w; size = sz; wdata = wd;
        r_lat = 0; r_cyc = 0; r_chg = 0; r_cs = '0; r_last = '0; r_rd = '0; r_err = 1'b0;
        r_gap = 0; r_gapcs = 1'b0; prev = '0;
        @(negedge clk);
        req = 1'b0;
        for (int i = 1; i < 200; i++) begin
            if (cs != '0) begin
                r_cyc++;
                r_cs |= cs;
                if (r_cyc > 1 && dev_addr != prev) r_chg++;
                prev = dev_addr;
                r_last = dev_addr;
            end
            if (done) begin
                r_lat = i; r_rd = rdata; r_err = err;
                break;
            end
            @(negedge clk);
        end
        while (!ready && r_gap < 100) begin
            @(negedge clk);
            r_gap++;
            if (cs != '0) r_gapcs = 1'b1;
        end
    endtask

    function automatic int beats(input int wc, input int nb);
        if (wc == 0) return nb;
        if (wc == 1) return (nb == 4) ? 2 : 1;
        return 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap [16];
        logic [31:0] expd, wd;
        int n_acc, mism, nb, bt, db;
        for (int k = 0; k < 4; k++) begin
            cw[k] = 2'd2; wt[k] = 4'd0; sp[k] = 4'd0;
            for (int i = 0; i < 64; i++) mem[k][i] = 8'((k * 64 + i) * 7 + 3);
        end
        n_acc = 0;
        repeat (3) @(negedge clk);
        chk("R10 cs after reset", 32'(cs), 32'h0);
        chk("R10 ready after reset", 32'(ready), 32'h1);
        chk("R10 done after reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: swap is off after reset even for address zero
        do_acc(24'h000000, 1'b0, 2'd2, 32'h0);
        chk("R9 reset swap off cs", 32'(r_cs), 32'h1);

        // sweep: region, width code, wait, stop, size, offset
        for (int k = 0; k < 4; k++)
        for (int wc = 0; wc < 4; wc++)
        for (int w = 0; w < 3; w += 2)
        for (int s = 0; s < 2; s++)
        for (int sz = 0; sz < 3; sz++)
        for (int o = 8; o < 12; o++) begin
            nb = 1 << sz;
            if ((o % nb) != 0) continue;
            for (int m = 0; m < 4; m++) begin
                cw[m] = 2'(wc); wt[m] = 4'(w); sp[m] = 4'(s);
            end
            db = (wc >= 2) ? 4 : (1 << wc);
            bt = beats(wc >= 2 ? 2 : wc, nb);
            n_acc++;
            wd = 32'h9E3779B9 * n_acc;
            for (int i = 0; i < 16; i++) snap[i] = mem[k][i];
            // write
            do_acc(24'((k << 20) | o), 1'b1, 2'(sz), wd);
            chk("R1 write cs", 32'(r_cs), 32'(1 << k));
            chk("R3 write latency", 32'(r_lat), 32'(bt * (w + 1) + 1));
            chk("R3 write cs length", 32'(r_cyc), 32'(bt * (w + 1)));
            chk("R4 write addr steps", 32'(r_chg), 32'(bt - 1));
            chk("R4 write last addr", 32'(r_last), 32'(o + (bt - 1) * db));
            chk("R7 stop gap", 32'(r_gap), 32'(s));
            chk("R7 cs low in gap", 32'(r_gapcs), 32'h0);
            mism = 0;
            for (int i = 0; i < 16; i++) begin
                logic [7:0] e;
                e = snap[i];
                if (i >= o && i < o + nb) e = wd[8 * ((o % 4) + (i - o)) +: 8];
                if (mem[k][i] !== e) mism++;
            end
            chk("R6 written bytes", 32'(mism), 32'h0);
            // read back
            do_acc(24'((k << 20) | o), 1'b0, 2'(sz), 32'h0);
            expd = '0;
            for (int i = 0; i < nb; i++) expd[8 * ((o % 4) + i) +: 8] = mem[k][o + i];
            chk("R5 read data", r_rd, expd);
            chk("R3 read latency", 32'(r_lat), 32'(bt * (w + 1) + 1));
            chk("R1 read cs", 32'(r_cs), 32'(1 << k));
            chk("R2 good access no err", 32'(r_err), 32'h0);
        end

        // R2 rejections
        for (int m = 0; m < 4; m++) begin cw[m] = 2'd0; wt[m] = 4'd1; sp[m] = 4'd1; end
        do_acc(24'h400000, 1'b0, 2'd0, 32'h0);
        chk("R2 out of range err", 32'({r_err, r_cs}), 32'h10);
        chk("R2 out of range latency", 32'(r_lat), 32'h1);
        do_acc(24'hF00010, 1'b1, 2'd2, 32'h0);
        chk("R2 high range err", 32'({r_err, r_cs}), 32'h10);
        do_acc(24'h100002, 1'b0, 2'd2, 32'h0);
        chk("R2 misaligned word", 32'({r_err, r_cs}), 32'h10);
        do_acc(24'h200001, 1'b0, 2'd1, 32'h0);
        chk("R2 misaligned half", 32'({r_err, r_cs}), 32'h10);
        do_acc(24'h300000, 1'b0, 2'd3, 32'h0);
        chk("R2 bad size", 32'({r_err, r_cs}), 32'h10);
        chk("R2 reject latency", 32'(r_lat), 32'h1);

        // R8 swap: region 0 is 8-bit, region 3 is 32-bit
        cw[0] = 2'd0; cw[1] = 2'd1; cw[2] = 2'd2; cw[3] = 2'd2;
        for (int m = 0; m < 4; m++) begin wt[m] = 4'd0; sp[m] = 4'd0; end
        wt[0] = 4'd3;
        fork
            do_acc(24'h000000, 1'b0, 2'd2, 32'h0);
            begin repeat (3) @(negedge clk); swap_in = 1'b1; end
        join
        chk("R9 swap mid access keeps cs", 32'(r_cs), 32'h1);
        chk("R9 swap mid access latency", 32'(r_lat), 32'(4 * 4 + 1));
        @(negedge clk);
        do_acc(24'h000000, 1'b0, 2'd2, 32'h0);
        chk("R8 addr0 swapped cs", 32'(r_cs), 32'h8);
        chk("R8 addr0 uses region3 width", 32'(r_lat), 32'h2);
        chk("R8 addr0 swapped data", r_rd,
            {mem[3][3], mem[3][2], mem[3][1], mem[3][0]});
        do_acc(24'h300004, 1'b0, 2'd2, 32'h0);
        chk("R8 region3 addr swapped cs", 32'(r_cs), 32'h1);
        chk("R8 region3 addr uses region0 timing", 32'(r_lat), 32'(4 * 4 + 1));
        chk("R8 region3 addr data", r_rd, {mem[0][7], mem[0][6], mem[0][5], mem[0][4]});
        do_acc(24'h100000, 1'b0, 2'd2, 32'h0);
        chk("R8 region1 unchanged", 32'(r_cs), 32'h2);
        do_acc(24'h200000, 1'b0, 2'd2, 32'h0);
        chk("R8 region2 unchanged", 32'(r_cs), 32'h4);
        swap_in = 1'b0;
        @(negedge clk);
        do_acc(24'h000000, 1'b0, 2'd0, 32'h0);
        chk("R9 swap cleared when idle", 32'(r_cs), 32'h1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule